// File: doc/BRIEF.md
# Hyperframe control-word demultiplexer

This block sits behind the framing stage of a radio-link receiver. It takes a word-aligned stream, one word per clock, in which a start-of-frame marker flags the first word of every basic frame. That first word is the control word, and the remaining fifteen words carry IQ payload. The payload words leave on their own output with a valid strobe and their position inside the basic frame.

Control words are numbered by a basic-frame index that runs through a 256-frame hyperframe. The index is aligned by a sync control word, which is a control word equal to a build-time pattern. Each control word is then steered to one of four channels:
- the timing channel, which carries index 0 together with the hyperframe count;
- the slow management channel, which carries index 1;
- the fast management channel, which carries every index whose value modulo 64 is at or above a programmable pointer;
- a general channel, which carries all remaining indices.

The pointer can be written at run time, but only values from 16 to 63 are accepted. Until the first sync control word arrives, the block reports that it is unlocked and emits nothing.

Top module: `hfcw_demux`

## Requirements
- R1: A word with `in_valid`=1 and `in_sof`=0 is an IQ word. While locked, it appears one clock later on `iq_data` with `iq_valid`=1 and `iq_pos` set to its position in the basic frame: 1 for the word right after the control word, up to 15. A control word never raises `iq_valid`.
- R2: After reset `unlocked`=1. While unlocked, all five valid strobes stay 0 and non-sync control words are ignored. `unlocked` falls with the outputs of the first sync control word and stays 0 until reset.
- R3: A sync control word (`in_data` equal to `SYNC_WORD`, default 16'h50BC) forces the basic-frame index to 0. One clock later it appears on the timing channel: `tim_valid`=1, `cw_bf_idx`=0, `cw_data` holds the word, and `tim_hfn` holds the hyperframe count.
- R4: While locked, each non-sync control word takes the previous index plus one, and 255 is followed by 0. The hyperframe count increments on every step from 255 to 0. The control word at index 0 goes to the timing channel even when it is not a sync word.
- R5: The control word at index 1 goes to the slow channel (`slow_valid`=1).
- R6: A control word whose index modulo 64 is at least the pointer `ptr_q` goes to the fast channel (`fast_valid`=1).
- R7: Every other locked control word goes to the general channel (`gen_valid`=1), including indices 64, 128 and 192. Exactly one channel strobe is raised per locked control word.
- R8: After reset `ptr_q`=20. A write (`ptr_wr`=1) of a value from 16 to 63 takes effect on `ptr_q` at the next clock edge. A write of any other value leaves `ptr_q` unchanged.
- R9: A sync control word that arrives while locked at an expected index other than 0 raises `resync_err` for exactly one clock, together with its timing-channel output. It realigns the index to 0 and leaves the hyperframe count unchanged.
- R10: A sync control word that arrives exactly at the 255-to-0 step raises no `resync_err` and increments the hyperframe count.
- R11: In reset, all valid strobes, `resync_err` and `tim_hfn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Word is the first (control) word of a basic frame |
| in_data | input | WORD_W | Input word |
| ptr_wr | input | 1 | Fast-channel pointer write strobe |
| ptr_wdata | input | IDX_W | Pointer write value |
| ptr_q | output | GRP_W | Current fast-channel pointer |
| unlocked | output | 1 | No sync control word seen since reset |
| iq_valid | output | 1 | IQ word output strobe |
| iq_pos | output | POS_W | Word position of the IQ word (1..15) |
| iq_data | output | WORD_W | IQ word |
| tim_valid | output | 1 | Timing-channel strobe |
| tim_hfn | output | HFN_W | Hyperframe count for the timing word |
| slow_valid | output | 1 | Slow management channel strobe |
| fast_valid | output | 1 | Fast management channel strobe |
| gen_valid | output | 1 | General channel strobe |
| cw_data | output | WORD_W | Control word for whichever channel strobe is high |
| cw_bf_idx | output | IDX_W | Basic-frame index of that control word |
| resync_err | output | 1 | Sync control word at an unexpected index |

## Verification
The bench walks a full hyperframe and checks the channel at each edge of the fast window:
- just below the pointer, at the pointer, at 63, and at the first index of each 64-frame group.

A design that compared the full index against the pointer would send the upper groups to the general channel. A design with an off-by-one in the window would misplace index 19 or 20.

It then checks the hyperframe count across two kinds of 255-to-0 wrap, one marked by a sync word and one by a plain control word. A design that counted only one kind would leave the count stale.

It places a sync word in mid-hyperframe and checks three things:
- a single-cycle error pulse;
- realignment, since the next frame must land on the slow channel;
- an unchanged count.

Finally it writes pointer values just outside the 16-to-63 range and at both limits, which exposes a missing or off-by-one range check.

// File: rtl/hfcw_pkg.sv
// Shared types for the hyperframe control-word demultiplexer.
package hfcw_pkg;
    // Destination of one control word.
    typedef enum logic [1:0] {
        CH_GEN  = 2'd0,
        CH_TIM  = 2'd1,
        CH_SLOW = 2'd2,
        CH_FAST = 2'd3
    } cw_chan_e;
endpackage

// File: rtl/hfcw_ptr_reg.sv
// Fast-window pointer register.
// Holds the first index (modulo the group size) of the fast management window.
// Assumes writes arrive as single-cycle strobes; out-of-range values are dropped.
module hfcw_ptr_reg #(
    parameter int WR_W    = 8,
    parameter int PTR_W   = 6,
    parameter int PTR_MIN = 16,
    parameter int PTR_MAX = 63,
    parameter int PTR_RST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    output logic [PTR_W-1:0] ptr
);
    logic in_range;

    // Range check on the incoming write value.
    always_comb begin
        in_range = (wr_data >= WR_W'(PTR_MIN)) && (wr_data <= WR_W'(PTR_MAX));
    end

    // Load the pointer on an accepted write; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= PTR_W'(PTR_RST);
        end else if (wr_en && in_range) begin
            ptr <= wr_data[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/hfcw_route.sv
// Control-word channel classifier.
// Maps a basic-frame index and the fast pointer to a destination channel.
// Assumes the pointer is at least 2, so the fast window never overlaps indices 0 and 1.
module hfcw_route
    import hfcw_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int GRP_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [GRP_W-1:0] ptr,
    output cw_chan_e         chan
);
    // Priority: timing, then slow, then the fast window, else general.
    always_comb begin
        if (idx == '0) begin
            chan = CH_TIM;
        end else if (idx == IDX_W'(1)) begin
            chan = CH_SLOW;
        end else if (idx[GRP_W-1:0] >= ptr) begin
            chan = CH_FAST;
        end else begin
            chan = CH_GEN;
        end
    end
endmodule

// File: rtl/hfcw_track.sv
// Basic-frame and hyperframe tracker.
// Keeps the lock state, the basic-frame index, the hyperframe count and the
// IQ word position. It presents the next-state values so that the top can
// register them together with the data.
// Assumes the start-of-frame marker is only raised on valid words.
module hfcw_track #(
    parameter int IDX_W = 8,
    parameter int HFN_W = 8,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             is_sync,
    output logic [IDX_W-1:0] idx_next,
    output logic [HFN_W-1:0] hfn_next,
    output logic             cw_emit,
    output logic             iq_emit,
    output logic [POS_W-1:0] iq_pos_now,
    output logic             resync,
    output logic             locked
);
    logic [IDX_W-1:0] idx_q;
    logic [HFN_W-1:0] hfn_q;
    logic [POS_W-1:0] wpos_q;
    logic [IDX_W-1:0] expected;
    logic             is_cw;

    // Next index, hyperframe count, emit and error decisions.
    always_comb begin
        expected = idx_q + 1'b1;
        is_cw    = in_valid && in_sof;
        idx_next = idx_q;
        hfn_next = hfn_q;
        resync   = 1'b0;
        if (is_cw && is_sync) begin
            idx_next = '0;
            resync   = locked && (expected != '0);
            if (locked && (expected == '0)) begin
                hfn_next = hfn_q + 1'b1;
            end
        end else if (is_cw && locked) begin
            idx_next = expected;
            if (expected == '0) begin
                hfn_next = hfn_q + 1'b1;
            end
        end
        cw_emit    = is_cw && (is_sync || locked);
        iq_emit    = in_valid && !in_sof && locked;
        iq_pos_now = wpos_q;
    end

    // State update: index, count, lock and word position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            hfn_q  <= '0;
            locked <= 1'b0;
            wpos_q <= POS_W'(1);
        end else begin
            idx_q <= idx_next;
            hfn_q <= hfn_next;
            if (in_valid && in_sof && is_sync) begin
                locked <= 1'b1;
            end
            if (in_valid) begin
                wpos_q <= in_sof ? POS_W'(1) : wpos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hfcw_demux.sv
// Hyperframe control-word demultiplexer (top).
// Splits the control word of each basic frame from the IQ words and steers it
// to the timing, slow, fast or general channel, according to its index in the
// hyperframe and the fast pointer. All outputs are registered, so there is one
// clock of latency. Assumes a word-aligned input with one start-of-frame
// marker on the control word of each basic frame.
module hfcw_demux
    import hfcw_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter logic [WORD_W-1:0] SYNC_WORD = 16'h50BC,
    parameter int              HF_LEN    = 256,
    parameter int              GRP_LEN   = 64,
    parameter int              BF_WORDS  = 16,
    parameter int              PTR_MIN   = 16,
    parameter int              PTR_RST   = 20,
    parameter int              HFN_W     = 8,
    localparam int             IDX_W     = $clog2(HF_LEN),
    localparam int             GRP_W     = $clog2(GRP_LEN),
    localparam int             POS_W     = $clog2(BF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    input  logic              ptr_wr,
    input  logic [IDX_W-1:0]  ptr_wdata,
    output logic [GRP_W-1:0]  ptr_q,
    output logic              unlocked,
    output logic              iq_valid,
    output logic [POS_W-1:0]  iq_pos,
    output logic [WORD_W-1:0] iq_data,
    output logic              tim_valid,
    output logic [HFN_W-1:0]  tim_hfn,
    output logic              slow_valid,
    output logic              fast_valid,
    output logic              gen_valid,
    output logic [WORD_W-1:0] cw_data,
    output logic [IDX_W-1:0]  cw_bf_idx,
    output logic              resync_err
);
    logic             is_sync;
    logic [IDX_W-1:0] idx_next;
    logic [HFN_W-1:0] hfn_next;
    logic             cw_emit;
    logic             iq_emit;
    logic [POS_W-1:0] iq_pos_now;
    logic             resync;
    logic             locked;
    cw_chan_e         chan;

    // Sync pattern compare on the incoming word.
    always_comb begin
        is_sync = (in_data == SYNC_WORD);
    end

    hfcw_ptr_reg #(
        .WR_W(IDX_W), .PTR_W(GRP_W), .PTR_MIN(PTR_MIN),
        .PTR_MAX(GRP_LEN - 1), .PTR_RST(PTR_RST)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_data(ptr_wdata), .ptr(ptr_q)
    );

    hfcw_track #(.IDX_W(IDX_W), .HFN_W(HFN_W), .POS_W(POS_W)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .is_sync(is_sync), .idx_next(idx_next), .hfn_next(hfn_next),
        .cw_emit(cw_emit), .iq_emit(iq_emit), .iq_pos_now(iq_pos_now),
        .resync(resync), .locked(locked)
    );

    hfcw_route #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_route (
        .idx(idx_next), .ptr(ptr_q), .chan(chan)
    );

    // Lock flag seen at the ports.
    always_comb begin
        unlocked = !locked;
    end

    // Output registers: channel strobes, data, index and IQ path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_valid   <= 1'b0;
            iq_pos     <= '0;
            iq_data    <= '0;
            tim_valid  <= 1'b0;
            tim_hfn    <= '0;
            slow_valid <= 1'b0;
            fast_valid <= 1'b0;
            gen_valid  <= 1'b0;
            cw_data    <= '0;
            cw_bf_idx  <= '0;
            resync_err <= 1'b0;
        end else begin
            iq_valid   <= iq_emit;
            tim_valid  <= cw_emit && (chan == CH_TIM);
            slow_valid <= cw_emit && (chan == CH_SLOW);
            fast_valid <= cw_emit && (chan == CH_FAST);
            gen_valid  <= cw_emit && (chan == CH_GEN);
            resync_err <= resync;
            if (iq_emit) begin
                iq_pos  <= iq_pos_now;
                iq_data <= in_data;
            end
            if (cw_emit) begin
                cw_data   <= in_data;
                cw_bf_idx <= idx_next;
                tim_hfn   <= hfn_next;
            end
        end
    end
endmodule

// File: rtl/hfcw_demux_chk.sv
// Property checker for hfcw_demux, attached with bind below.
module hfcw_demux_chk #(
    parameter int IDX_W = 8,
    parameter int GRP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unlocked,
    input logic             iq_valid,
    input logic             tim_valid,
    input logic             slow_valid,
    input logic             fast_valid,
    input logic             gen_valid,
    input logic [IDX_W-1:0] cw_bf_idx,
    input logic [GRP_W-1:0] ptr_q,
    input logic             resync_err
);
    logic any_cw;

    // Any channel strobe.
    always_comb begin
        any_cw = tim_valid || slow_valid || fast_valid || gen_valid;
    end

    p_iq_not_cw_r1: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> !any_cw);
    p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> !(any_cw || iq_valid));
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> !unlocked);
    p_tim_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tim_valid |-> (cw_bf_idx == '0));
    p_slow_at_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slow_valid |-> (cw_bf_idx == IDX_W'(1)));
    p_fast_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fast_valid |-> (cw_bf_idx[GRP_W-1:0] >= ptr_q));
    p_one_channel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tim_valid, slow_valid, fast_valid, gen_valid}));
    p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q >= GRP_W'(16)));
    p_resync_on_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resync_err |-> tim_valid);
endmodule

bind hfcw_demux hfcw_demux_chk #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .iq_valid(iq_valid),
    .tim_valid(tim_valid), .slow_valid(slow_valid), .fast_valid(fast_valid),
    .gen_valid(gen_valid), .cw_bf_idx(cw_bf_idx), .ptr_q(ptr_q),
    .resync_err(resync_err)
);

// File: tb/hfcw_demux_test.sv
// Bench for hfcw_demux. Channel codes used below: 0 general, 1 timing,
// 2 slow, 3 fast, 7 no strobe or more than one strobe.
module hfcw_demux_test;
    localparam logic [15:0] SYNC = 16'h50BC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [15:0] in_data = '0;
    logic        ptr_wr = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic [5:0]  ptr_q;
    logic        unlocked, iq_valid, tim_valid, slow_valid, fast_valid, gen_valid, resync_err;
    logic [3:0]  iq_pos;
    logic [15:0] iq_data, cw_data;
    logic [7:0]  tim_hfn, cw_bf_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_hfn = 0;
    logic [2:0]  cap_ch [256];
    logic [7:0]  cap_idx [256];
    logic [15:0] cap_dat [256];

    // Expected channel per index for pointer 20: {index, code}.
    localparam logic [10:0] VEC [13] = '{
        {8'd0, 3'd1}, {8'd1, 3'd2}, {8'd2, 3'd0}, {8'd19, 3'd0}, {8'd20, 3'd3},
        {8'd63, 3'd3}, {8'd64, 3'd0}, {8'd65, 3'd0}, {8'd84, 3'd3}, {8'd128, 3'd0},
        {8'd147, 3'd0}, {8'd148, 3'd3}, {8'd255, 3'd3}
    };

    hfcw_demux uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ptr_q(ptr_q), .unlocked(unlocked),
        .iq_valid(iq_valid), .iq_pos(iq_pos), .iq_data(iq_data), .tim_valid(tim_valid),
        .tim_hfn(tim_hfn), .slow_valid(slow_valid), .fast_valid(fast_valid),
        .gen_valid(gen_valid), .cw_data(cw_data), .cw_bf_idx(cw_bf_idx),
        .resync_err(resync_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] chan_code();
        int n = int'(tim_valid) + int'(slow_valid) + int'(fast_valid) + int'(gen_valid);
        if (n != 1) return 3'd7;
        if (tim_valid) return 3'd1;
        if (slow_valid) return 3'd2;
        if (fast_valid) return 3'd3;
        return 3'd0;
    endfunction

    // Drive one word for one clock and sample the registered outputs after it.
    task automatic drive(input logic sof, input logic [15:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic write_ptr(input logic [7:0] v);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = v;
        @(posedge clk); #1;
        ptr_wr = 1'b0;
    endtask

    // Send control words for indices lo..hi and capture their outputs.
    task automatic walk(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            drive(1'b1, 16'h1000 + 16'(i));
            cap_ch[i] = chan_code(); cap_idx[i] = cw_bf_idx; cap_dat[i] = cw_data;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11, R8, R2: reset state
        repeat (3) @(posedge clk); #1;
        chk(chan_code() == 3'd7 && !iq_valid && !resync_err, "R11", "strobes in reset", int'(chan_code()), 7);
        chk(tim_hfn == 0, "R11", "hfn in reset", int'(tim_hfn), 0);
        chk(ptr_q == 6'd20, "R8", "pointer reset value", int'(ptr_q), 20);
        chk(unlocked, "R2", "unlocked after reset", int'(unlocked), 1);
        @(negedge clk); rst_n = 1'b1;

        // R2: unlocked stream is silent
        for (int f = 0; f < 3; f++) begin
            drive(1'b1, 16'h2222);
            chk(chan_code() == 3'd7, "R2", "cw strobe while unlocked", int'(chan_code()), 7);
            for (int w = 1; w < 16; w++) begin
                drive(1'b0, 16'h3000 + 16'(w));
                chk(!iq_valid, "R2", "iq strobe while unlocked", int'(iq_valid), 0);
            end
        end
        chk(unlocked, "R2", "still unlocked", int'(unlocked), 1);

        // R3, R1: first sync word, then a full IQ block
        drive(1'b1, SYNC);
        chk(tim_valid && chan_code() == 3'd1, "R3", "sync on timing", int'(chan_code()), 1);
        chk(cw_bf_idx == 0 && tim_hfn == 0, "R3", "sync index/hfn", int'(cw_bf_idx), 0);
        chk(cw_data == SYNC, "R3", "sync data", int'(cw_data), int'(SYNC));
        chk(!unlocked && !resync_err, "R2", "lock on first sync", int'(unlocked), 0);
        for (int w = 1; w < 16; w++) begin
            drive(1'b0, 16'hA000 + 16'(w));
            chk(iq_valid && iq_pos == 4'(w) && iq_data == 16'hA000 + 16'(w), "R1",
                "iq word position", int'(iq_pos), w);
            chk(chan_code() == 3'd7, "R1", "no cw strobe on iq", int'(chan_code()), 7);
        end

        // R5, R6, R7, R4: walk one hyperframe, then check the vector table
        walk(1, 255);
        for (int k = 0; k < 13; k++) begin
            int ix = int'(VEC[k][10:3]);
            if (ix == 0) continue;
            chk(cap_ch[ix] == VEC[k][2:0], ix == 1 ? "R5" : (VEC[k][2:0] == 3 ? "R6" : "R7"),
                $sformatf("channel at index %0d", ix), int'(cap_ch[ix]), int'(VEC[k][2:0]));
            chk(cap_idx[ix] == 8'(ix) && cap_dat[ix] == 16'h1000 + 16'(ix), "R4",
                $sformatf("index/data at %0d", ix), int'(cap_idx[ix]), ix);
        end

        // R10: sync exactly at the wrap
        drive(1'b1, SYNC); exp_hfn = 1;
        chk(tim_valid && cw_bf_idx == 0 && !resync_err, "R10", "sync at wrap", int'(resync_err), 0);
        chk(tim_hfn == 8'(exp_hfn), "R10", "hfn after sync wrap", int'(tim_hfn), exp_hfn);

        // R8: pointer writes
        write_ptr(8'd64);
        chk(ptr_q == 6'd20, "R8", "reject 64", int'(ptr_q), 20);
        write_ptr(8'd15);
        chk(ptr_q == 6'd20, "R8", "reject 15", int'(ptr_q), 20);
        write_ptr(8'd16);
        chk(ptr_q == 6'd16, "R8", "accept 16", int'(ptr_q), 16);
        write_ptr(8'd63);
        chk(ptr_q == 6'd63, "R8", "accept 63", int'(ptr_q), 63);
        write_ptr(8'd40);
        chk(ptr_q == 6'd40, "R8", "accept 40", int'(ptr_q), 40);

        // R6, R7 at pointer 40; R4 wrap without sync
        walk(1, 255);
        chk(cap_ch[39] == 3'd0, "R7", "index 39 ptr 40", int'(cap_ch[39]), 0);
        chk(cap_ch[40] == 3'd3, "R6", "index 40 ptr 40", int'(cap_ch[40]), 3);
        chk(cap_ch[103] == 3'd0, "R7", "index 103 ptr 40", int'(cap_ch[103]), 0);
        chk(cap_ch[104] == 3'd3, "R6", "index 104 ptr 40", int'(cap_ch[104]), 3);
        chk(cap_ch[192] == 3'd0, "R7", "index 192 ptr 40", int'(cap_ch[192]), 0);
        drive(1'b1, 16'h7777); exp_hfn = 2;
        chk(tim_valid && cw_bf_idx == 0, "R4", "plain wrap to timing", int'(cw_bf_idx), 0);
        chk(tim_hfn == 8'(exp_hfn), "R4", "hfn after plain wrap", int'(tim_hfn), exp_hfn);

        // R9: sync in mid-hyperframe
        walk(1, 49);
        drive(1'b1, SYNC);
        chk(resync_err && tim_valid, "R9", "resync pulse", int'(resync_err), 1);
        chk(cw_bf_idx == 0 && tim_hfn == 8'(exp_hfn), "R9", "hfn unchanged", int'(tim_hfn), exp_hfn);
        drive(1'b1, 16'h4444);
        chk(!resync_err, "R9", "pulse one clock", int'(resync_err), 0);
        chk(slow_valid && cw_bf_idx == 1, "R9", "realigned to index 1", int'(cw_bf_idx), 1);

        // R11, R2, R8: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk(unlocked && ptr_q == 6'd20, "R11", "reset restores pointer", int'(ptr_q), 20);
        @(negedge clk); rst_n = 1'b1;
        drive(1'b1, 16'h4444);
        chk(chan_code() == 3'd7, "R2", "silent after second reset", int'(chan_code()), 7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule